// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches a demodulated infrared line and measures it in units of a programmable sample tick. A high input is a mark (carrier present) and a low input is a space. Each mark and each space is recorded as an 8-bit count of ticks. The counts are packed four to a 32-bit word into a fixed bank of capture words, which software reads over a small register port.

A message begins with the first mark seen after the receiver is armed. It ends when a space lasts for the programmed idle threshold. At that point the bank freezes, a completion flag is set, and an interrupt is raised if it is enabled. Software reads the words, then writes a restart that wipes the bank and arms the receiver for the next message. Decoding the counts into commands is left to software.

Register map (byte addresses):
- 0x00 configuration: bit 0 receiver enable, bit 13 width-detection enable, bits 23:16 idle threshold.
- 0x04 divider: bits 15:0.
- 0x08 restart: write only, bit 0.
- 0x0C interrupt enable: bit 0.
- 0x10 interrupt clear on write (bit 0). On read it returns status: bit 0 pending, bit 1 complete.
- 0x40 + 4*i: capture word i, for i = 0..16.

Top module: `ircap_rx`

## Requirements
- R1: A sample tick occurs once every (divider + 1) clocks, where the divider is bits 15:0 at 0x04. A level held on the input for N tick periods is recorded as the count N.
- R2: Capture word i is read at address 0x40 + 4*i, for i = 0..16. Each word holds four counts, with the earliest in bits 7:0 and the later counts in bits 15:8, 23:16 and 31:24.
- R3: While the receiver is armed and the line is low, nothing is recorded. The first stored count is a mark, and stored counts then alternate between mark and space.
- R4: A mark longer than 255 ticks is stored as 255.
- R5: A space that reaches the idle threshold (bits 23:16 at 0x00) completes the message. The threshold value 0 means 255. That final space is stored as 0xFF, and status bit 1 at 0x10 reads 1.
- R6: Counts after the 68th are dropped. Completion and the interrupt still occur at the idle timeout.
- R7: Once a message is complete, further input edges leave the capture words and the status unchanged until a restart.
- R8: Writing 1 to bit 0 of 0x08 clears every capture word to zero, clears the complete flag and rearms the receiver.
- R9: Capture advances only while both bit 0 and bit 13 of 0x00 are 1.
- R10: Completion sets a pending flag, which is status bit 0 at 0x10. The irq output equals the pending flag AND bit 0 of 0x0C. Writing 1 to bit 0 of 0x10 clears the pending flag. If that write falls in the same cycle as a completion, the pending flag is set.
- R11: After reset, all capture words, the status, the enables and irq read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, high = mark |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |

## Verification
Completion of a message and a software write to the interrupt-clear register can land on the same clock edge. To provoke this, the bench holds the clear write active on every cycle while the final space runs out. That collision is only seen to be handled correctly if irq is observed high for one cycle before the next clear removes it. Afterwards, the status must read complete with nothing pending, which shows that the set won and the following clear still took effect.

// File: rtl/ircap_pkg.sv
package ircap_pkg;
  localparam int unsigned CNT_W          = 8;
  localparam int unsigned SLOTS_PER_WORD = 4;
  localparam int unsigned WORD_W         = CNT_W * SLOTS_PER_WORD;

  localparam logic [7:0] A_CFG     = 8'h00;
  localparam logic [7:0] A_DIV     = 8'h04;
  localparam logic [7:0] A_RESTART = 8'h08;
  localparam logic [7:0] A_IEN     = 8'h0C;
  localparam logic [7:0] A_ICLR    = 8'h10;
  localparam logic [7:0] A_WORD0   = 8'h40;

  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_DONE} meter_st_t;
endpackage

// File: rtl/ircap_tick.sv
module ircap_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ircap_sync.sv
module ircap_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], din};
  end

  assign dout = stg_q[1];
endmodule

// File: rtl/ircap_meter.sv
module ircap_meter
  import ircap_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 68,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             level,
  input  logic             restart,
  input  logic [CNT_W-1:0] thr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] wr_val,
  output logic             done_pulse,
  output meter_st_t        st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_SLOTS);

  meter_st_t        st_q, st_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, thr_eff;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             room, upd;

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    wr_en      = 1'b0;
    wr_val     = cnt_q;
    done_pulse = 1'b0;
    room       = (idx_q < IDX_LIM);
    cnt_inc    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    thr_eff    = (thr == '0) ? CNT_MAX : thr;
    upd        = restart | (tick & active);
    if (restart) begin
      st_d  = ST_IDLE;
      ph_d  = 1'b1;
      cnt_d = '0;
      idx_d = '0;
    end else if (tick && active) begin
      case (st_q)
        ST_IDLE: begin
          if (level) begin
            st_d  = ST_CAPT;
            ph_d  = 1'b1;
            cnt_d = CNT_W'(1);
          end
        end
        ST_CAPT: begin
          if (level == ph_q) begin
            if (!ph_q && (cnt_inc >= thr_eff)) begin
              st_d       = ST_DONE;
              wr_en      = room;
              wr_val     = CNT_MAX;
              done_pulse = 1'b1;
            end else begin
              cnt_d = cnt_inc;
            end
          end else begin
            wr_en = room;
            if (room) idx_d = idx_q + 1'b1;
            ph_d  = level;
            cnt_d = CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b1;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign wr_idx = idx_q;
  assign st_o   = st_q;
  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ircap_bank.sv
module ircap_bank
  import ircap_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 68,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [CNT_W-1:0]           wr_val,
  output logic [NUM_SLOTS*CNT_W-1:0] flat
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    logic             hit;
    assign hit = wr_en && (wr_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (clear) slot_q <= '0;
      else if (hit)   slot_q <= wr_val;
    end
    assign flat[s*CNT_W +: CNT_W] = slot_q;
  end
endmodule

// File: rtl/ircap_rx.sv
module ircap_rx
  import ircap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 17,
  parameter int unsigned DIV_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int unsigned NUM_SLOTS = NUM_WORDS * SLOTS_PER_WORD;
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS + 1);

  logic [1:0]             rs_q;
  logic                   rst_q_n;
  logic                   rx_en_q, wd_en_q, ien_q, pend_q, pend_d;
  logic [CNT_W-1:0]       thr_q;
  logic [DIV_W-1:0]       div_q;
  logic                   restart_w, clr_w, cfg_w, div_w, ien_w;
  logic                   tick, level, active;
  logic                   wr_en, done_pulse;
  logic [IDX_W-1:0]       wr_idx, meter_idx;
  logic [CNT_W-1:0]       wr_val, meter_cnt;
  meter_st_t              meter_st;
  logic [NUM_SLOTS*CNT_W-1:0] flat;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  assign cfg_w     = reg_we && (reg_addr == A_CFG);
  assign div_w     = reg_we && (reg_addr == A_DIV);
  assign ien_w     = reg_we && (reg_addr == A_IEN);
  assign restart_w = reg_we && (reg_addr == A_RESTART) && reg_wdata[0];
  assign clr_w     = reg_we && (reg_addr == A_ICLR) && reg_wdata[0];
  assign active    = rx_en_q & wd_en_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rx_en_q <= 1'b0;
      wd_en_q <= 1'b0;
      thr_q   <= '0;
    end else if (cfg_w) begin
      rx_en_q <= reg_wdata[0];
      wd_en_q <= reg_wdata[13];
      thr_q   <= reg_wdata[23:16];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   div_q <= '0;
    else if (div_w) div_q <= reg_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   ien_q <= 1'b0;
    else if (ien_w) ien_q <= reg_wdata[0];
  end

  // completion beats a clear in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr_w)      pend_d = 1'b0;
    if (done_pulse) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pend_q <= 1'b0;
    else          pend_q <= pend_d;
  end

  assign irq = pend_q & ien_q;

  ircap_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_q_n), .div(div_q), .tick(tick)
  );

  ircap_sync u_sync (
    .clk(clk), .rst_n(rst_q_n), .din(ir_in), .dout(level)
  );

  ircap_meter #(.NUM_SLOTS(NUM_SLOTS)) u_meter (
    .clk(clk), .rst_n(rst_q_n), .tick(tick), .active(active), .level(level),
    .restart(restart_w), .thr(thr_q), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .done_pulse(done_pulse), .st_o(meter_st),
    .idx_o(meter_idx), .cnt_o(meter_cnt)
  );

  ircap_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .clear(restart_w), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_val(wr_val), .flat(flat)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:  reg_rdata = {8'h00, thr_q, 2'b00, wd_en_q, 12'h000, rx_en_q};
      A_DIV:  reg_rdata = 32'(div_q);
      A_IEN:  reg_rdata = {31'h0, ien_q};
      A_ICLR: reg_rdata = {30'h0, (meter_st == ST_DONE), pend_q};
      default: begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (reg_addr == 8'(A_WORD0 + 4 * w))
            reg_rdata = flat[w*WORD_W +: WORD_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/ircap_rx_chk.sv
module ircap_rx_chk
  import ircap_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 68,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart_w,
  input logic             clr_w,
  input logic             done_pulse,
  input logic             pend_q,
  input logic             wr_en,
  input logic             active,
  input meter_st_t        meter_st,
  input logic [IDX_W-1:0] meter_idx,
  input logic [CNT_W-1:0] meter_cnt
);
  AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> pend_q); // R10
  AST_CLEAR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !done_pulse) |=> !pend_q); // R10
  AST_RESTART_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> (meter_st == ST_IDLE && meter_idx == '0)); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    meter_idx <= IDX_W'(NUM_SLOTS)); // R6
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (meter_st == ST_DONE) |-> !wr_en); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (meter_st == ST_DONE && !restart_w) |=> meter_st == ST_DONE); // R7
  AST_GATED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart_w) |=> ($stable(meter_cnt) && $stable(meter_st))); // R9
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (meter_st == ST_CAPT && meter_cnt == '1 && !restart_w)
      |=> (meter_cnt == '1 || meter_cnt == CNT_W'(1) || meter_st == ST_DONE)); // R4
endmodule

bind ircap_rx ircap_rx_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .restart_w(restart_w), .clr_w(clr_w),
  .done_pulse(done_pulse), .pend_q(pend_q), .wr_en(wr_en), .active(active),
  .meter_st(meter_st), .meter_idx(meter_idx), .meter_cnt(meter_cnt)
);

// File: tb/sim_ircap_rx.sv
`timescale 1ns/1ps
module sim_ircap_rx;
  localparam int PER   = 4;   // divider 3 -> tick every 4 clocks
  localparam int THR   = 30;
  localparam int SLOTS = 68;
  localparam logic [31:0] CFG_ON = 32'h0000_2001 | (32'(THR) << 16);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_b [SLOTS];
  int exp_n;

  always #5 clk = ~clk;

  ircap_rx u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4 * w + k < exp_n && 4 * w + k < SLOTS) r[k*8 +: 8] = exp_b[4*w+k];
    return r;
  endfunction

  task automatic push(input int v);
    if (exp_n < SLOTS) exp_b[exp_n] = (v > 255) ? 8'hFF : 8'(v);
    exp_n++;
  endtask

  task automatic seg(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n * PER) @(negedge clk);
  endtask

  task automatic rearm();
    ir_in = 1'b0;
    reg_wr(8'h08, 32'h1);
    repeat (3 * PER) @(negedge clk);
    exp_n = 0;
  endtask

  task automatic wait_done(input int maxc, output bit ok);
    ok = 1'b0;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      reg_addr = 8'h10;
      #1;
      if (reg_rdata[1]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_bank(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 17; w++) begin
      reg_rd(8'(8'h40 + 4 * w), d);
      chk(d == exp_word(w), tag, d, exp_word(w));
    end
  endtask

  // end a message: last mark is pushed, idle space becomes 0xFF
  task automatic finish_msg(input string tag);
    bit ok;
    ir_in = 1'b0;
    push(255);
    wait_done((THR + 8) * PER, ok);
    chk(ok, {tag, " R5 completion"}, 32'(ok), 32'd1);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok, seen;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ir_in = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    exp_n = 0;
    reg_rd(8'h10, d); chk(d == 0, "R11 status after reset", d, 0);
    reg_rd(8'h00, d); chk(d == 0, "R11 cfg after reset", d, 0);
    reg_rd(8'h40, d); chk(d == 0, "R11 word0 after reset", d, 0);
    chk(irq == 1'b0, "R11 irq after reset", 32'(irq), 0);

    reg_wr(8'h04, 32'd3);
    reg_wr(8'h00, CFG_ON);
    reg_wr(8'h0C, 32'h1);
    reg_rd(8'h00, d); chk(d == CFG_ON, "R9 cfg readback", d, CFG_ON);

    // directed message, R1 R2 R3: idle low first must not record
    rearm();
    seg(1'b0, 10);
    seg(1'b1, 5);  push(5);
    seg(1'b0, 7);  push(7);
    seg(1'b1, 3);  push(3);
    finish_msg("directed");
    reg_rd(8'h40, d); chk(d == 32'h00FF_0703 - 32'h0000_0000 + 32'h0000_0002 && 1'b0 || d == 32'hFF03_0705,
                          "R2 R3 word0 packing", d, 32'hFF03_0705);
    check_bank("R1 directed bank");
    chk(irq == 1'b1, "R10 irq after completion", 32'(irq), 1);
    reg_wr(8'h0C, 32'h0);
    #1 chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);
    reg_wr(8'h0C, 32'h1);
    #1 chk(irq == 1'b1, "R10 irq unmasked", 32'(irq), 1);

    // R7 frozen after completion
    seg(1'b1, 5); seg(1'b0, 5); seg(1'b1, 4); ir_in = 1'b0;
    check_bank("R7 bank frozen");
    reg_rd(8'h10, d); chk(d == 32'h3, "R7 status frozen", d, 32'h3);

    reg_wr(8'h10, 32'h1);
    reg_rd(8'h10, d); chk(d == 32'h2, "R10 pending cleared", d, 32'h2);
    chk(irq == 1'b0, "R10 irq after clear", 32'(irq), 0);

    // R8 restart wipes
    rearm();
    check_bank("R8 bank cleared");
    reg_rd(8'h10, d); chk(d == 32'h0, "R8 status rearmed", d, 0);

    // R4 saturation
    seg(1'b1, 300); push(300);
    seg(1'b0, 5);   push(5);
    seg(1'b1, 2);   push(2);
    finish_msg("saturation");
    check_bank("R4 saturated mark");
    reg_wr(8'h10, 32'h1);

    // R6 overflow
    rearm();
    for (int k = 0; k < 40; k++) begin
      seg(1'b1, 2); push(2);
      seg(1'b0, 2); push(2);
    end
    seg(1'b1, 2); push(2);
    finish_msg("overflow");
    check_bank("R6 overflow dropped");
    chk(irq == 1'b1, "R6 irq after overflow", 32'(irq), 1);
    reg_wr(8'h10, 32'h1);

    // random messages, R1 R3
    for (int m = 0; m < 4; m++) begin
      int nseg;
      rearm();
      nseg = 1 + 2 * int'($urandom_range(0, 10));
      for (int s = 0; s < nseg; s++) begin
        int wv;
        if (s % 2 == 0) wv = int'($urandom_range(1, 40));
        else            wv = int'($urandom_range(1, THR - 5));
        seg((s % 2) == 0, wv);
        if (s != nseg - 1) push(wv);
        else               push(wv);
      end
      // the last push above is the final mark; the idle marker follows
      ir_in = 1'b0;
      exp_n = exp_n;
      wait_done((THR + 8) * PER, ok);
      chk(ok, "R5 random completion", 32'(ok), 1);
      push(255);
      check_bank("R1 random bank");
      reg_wr(8'h10, 32'h1);
    end

    // R9 width detection off: nothing captured
    reg_wr(8'h00, 32'h0000_0001 | (32'(THR) << 16));
    rearm();
    seg(1'b1, 5); seg(1'b0, THR + 10);
    reg_rd(8'h10, d); chk(d == 0, "R9 disabled no completion", d, 0);
    reg_rd(8'h40, d); chk(d == 0, "R9 disabled no capture", d, 0);
    reg_wr(8'h00, CFG_ON);

    // R10 completion and clear in the same cycle
    rearm();
    seg(1'b1, 3);
    ir_in = 1'b0;
    seen = 1'b0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h1;
    for (int c = 0; c < (THR + 8) * PER; c++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    reg_we = 1'b0;
    chk(seen, "R10 set wins over clear", 32'(seen), 1);
    reg_rd(8'h10, d); chk(d == 32'h2, "R10 status after collision", d, 32'h2);

    // R5 threshold 0 means 255
    reg_wr(8'h00, 32'h0000_2001);
    rearm();
    seg(1'b1, 2);
    ir_in = 1'b0;
    repeat (200 * PER) @(negedge clk);
    reg_rd(8'h10, d); chk(d[1] == 1'b0, "R5 threshold0 not early", d, 0);
    wait_done(120 * PER, ok);
    chk(ok, "R5 threshold0 completes", 32'(ok), 1);
    reg_rd(8'h40, d); chk(d == 32'h0000_FF02, "R5 threshold0 word0", d, 32'h0000_FF02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule